// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the combinational steering logic of a five-stage integer pipeline (fetch, decode, execute, memory, write-back). It reads the register numbers and the few control bits held in the pipeline latches. From them it works out where each operand of the execute-stage ALU should come from, and whether the front of the pipeline must pause. It also decides whether a branch resolved in decode must discard the instruction fetched behind it.

A result is bypassed to a dependent instruction as soon as a later latch holds it. The register-file copy is not awaited. A load whose result is wanted by the very next instruction cannot be bypassed in time. In that case the unit holds the program counter and the fetch/decode latch for a cycle and sends a bubble into execute. Branches compare their operands in decode. A branch operand still being computed in execute, or still being loaded, also pauses the front end, and a finished ALU result waiting in the memory latch is bypassed into the comparator instead. Fetch assumes branches are not taken, so a taken branch costs exactly one flushed fetch slot.

Top module: `hazard_ctl`

## Requirements
- R1: An execute-stage operand whose register number equals the memory-latch destination, while that latch writes a nonzero register, gets select 2'b10 (`fwd_a` for the first source, `fwd_b` for the second, each judged on its own register).
- R2: An operand matched only by a writing, nonzero write-back destination gets select 2'b01; with no match the select is 2'b00 (register file).
- R3: When both the memory latch and the write-back latch match an operand, the memory latch wins (select 2'b10).
- R4: A destination of register 0, or a latch whose write enable is clear, never causes a forward, a stall or an ID-stage bypass.
- R5: A load in execute whose nonzero destination equals either source register of the instruction in decode raises `pc_hold`, `ifid_hold` and `idex_bubble` together. In a running pipeline this gives exactly one lost cycle, after which the consumer takes the loaded value from write-back (select 2'b01). A non-load producer in execute causes no stall for a non-branch consumer.
- R6: A branch in decode stalls (same three outputs) when a source register matches a writing execute-stage destination, or a load in the memory latch. It does not stall for a non-load result in the memory latch or for write-back.
- R7: A branch source matching a non-load, writing, nonzero memory-latch destination raises `id_fwd_a`/`id_fwd_b` for that source; a write-back match does not.
- R8: A taken branch in decode that is not stalled raises `ifid_flush` for one cycle; an untaken branch, or a taken flag seen during a stall, does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | RW | First source register of the instruction in decode |
| id_rt | input | RW | Second source register of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_taken | input | 1 | Decode-stage comparator says the branch is taken |
| ex_rs | input | RW | First source register in execute |
| ex_rt | input | RW | Second source register in execute |
| ex_rd | input | RW | Destination register in execute |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RW | Destination register in the memory latch |
| mem_wen | input | 1 | Memory-latch instruction writes a register |
| mem_load | input | 1 | Memory-latch instruction is a load |
| wb_rd | input | RW | Destination register in the write-back latch |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Source select for the first ALU operand |
| fwd_b | output | 2 | Source select for the second ALU operand |
| id_fwd_a | output | 1 | Bypass memory-latch result to first branch operand |
| id_fwd_b | output | 1 | Bypass memory-latch result to second branch operand |
| pc_hold | output | 1 | Keep the program counter this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch this cycle |
| idex_bubble | output | 1 | Load zeroed control into the decode/execute latch |
| ifid_flush | output | 1 | Replace the fetch/decode latch with a no-op |

## Verification
The hardest conditions to reach are sequences, not single latch snapshots. One is the one-cycle load-use stall followed by the consumer picking up the load from write-back. Another is a branch that first stalls on a producer in execute and then, a cycle later, is bypassed from the memory latch and flushes. The bench runs a small behavioural pipeline model that reacts to the unit's hold, bubble and flush outputs and advances short instruction sequences. It then counts stall cycles and samples the selects when the consumer reaches execute. Each static case is also loaded straight into the model's latches for one cycle.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_branch,
  input  logic          id_taken,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int NOPS = 2;

  logic ex_live, ex_ld_live, mem_live, wb_live;
  assign ex_live    = ex_wen && (ex_rd != '0);
  assign ex_ld_live = ex_load && ex_wen && (ex_rd != '0);
  assign mem_live   = mem_wen && (mem_rd != '0);
  assign wb_live    = wb_wen && (wb_rd != '0);

  logic [RW-1:0] ex_src [NOPS];
  logic [RW-1:0] id_src [NOPS];
  logic [1:0]    sel    [NOPS];
  logic [NOPS-1:0] idf, ld_use, br_dep;

  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;
  assign id_src[0] = id_rs;
  assign id_src[1] = id_rt;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign sel[i] = (mem_live && mem_rd == ex_src[i]) ? 2'b10 :
                    (wb_live  && wb_rd  == ex_src[i]) ? 2'b01 : 2'b00;
    assign ld_use[i] = ex_ld_live && ex_rd == id_src[i];
    assign br_dep[i] = id_branch &&
                       ((ex_live && ex_rd == id_src[i]) ||
                        (mem_live && mem_load && mem_rd == id_src[i]));
    assign idf[i] = id_branch && mem_live && !mem_load && mem_rd == id_src[i];
  end

  logic stall;
  assign stall = (|ld_use) || (|br_dep);

  assign fwd_a       = sel[0];
  assign fwd_b       = sel[1];
  assign id_fwd_a    = idf[0];
  assign id_fwd_b    = idf[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = id_branch && id_taken && !stall;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] id_rs,
  input logic [RW-1:0] id_rt,
  input logic          id_branch,
  input logic          id_taken,
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic [RW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [RW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_load,
  input logic [RW-1:0] wb_rd,
  input logic          wb_wen,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          id_fwd_a,
  input logic          id_fwd_b,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_bubble,
  input logic          ifid_flush
);
  always_comb begin
    p_sel_code_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    p_mem_wins_r3: assert (!(mem_wen && wb_wen && mem_rd != '0 && mem_rd == wb_rd &&
                             mem_rd == ex_rs) || fwd_a == 2'b10);
    p_reg0_r4: assert (!(mem_rd == '0 && wb_rd == '0) || (fwd_a == 2'b00 && fwd_b == 2'b00));
    p_wen_r4: assert (!(!mem_wen && !wb_wen) || (fwd_a == 2'b00 && fwd_b == 2'b00));
    p_hold_set_r5: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    p_nobranch_r6: assert (id_branch || ex_load || !pc_hold);
    p_idfwd_r7: assert (!(id_fwd_a || id_fwd_b) || (id_branch && mem_wen && !mem_load));
    p_flush_r8: assert (!(ifid_flush && pc_hold) && (!ifid_flush || id_taken));
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.RW(RW)) u_chk (.*);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic       wen;
    logic       load;
    logic       br;
    logic       tk;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  ins_t idr = NOP, exr = NOP, memr = NOP, wbr = NOP;
  ins_t d_id, d_ex, d_mem, d_wb;
  ins_t prog [8];
  int   pc = 0;
  logic ld = 1'b0, run = 1'b0;

  logic [1:0] fwd_a, fwd_b;
  logic id_fwd_a, id_fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  hazard_ctl #(.RW(5)) u0 (
    .id_rs(idr.rs), .id_rt(idr.rt), .id_branch(idr.br), .id_taken(idr.tk),
    .ex_rs(exr.rs), .ex_rt(exr.rt), .ex_rd(exr.rd), .ex_wen(exr.wen), .ex_load(exr.load),
    .mem_rd(memr.rd), .mem_wen(memr.wen), .mem_load(memr.load),
    .wb_rd(wbr.rd), .wb_wen(wbr.wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush)
  );

  always @(posedge clk) begin
    if (ld) begin
      idr <= d_id; exr <= d_ex; memr <= d_mem; wbr <= d_wb;
    end else if (run) begin
      wbr  <= memr;
      memr <= exr;
      exr  <= pc_hold ? NOP : idr;
      idr  <= ifid_flush ? NOP : (pc_hold ? idr : prog[pc]);
      pc   <= pc_hold ? pc : pc + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic ins_t mk(int rs, int rt, int rd, bit wen, bit load, bit br, bit tk);
    ins_t i;
    i.rs = rs[4:0]; i.rt = rt[4:0]; i.rd = rd[4:0];
    i.wen = wen; i.load = load; i.br = br; i.tk = tk;
    return i;
  endfunction

  task automatic put(ins_t i_id, ins_t i_ex, ins_t i_mem, ins_t i_wb);
    d_id = i_id; d_ex = i_ex; d_mem = i_mem; d_wb = i_wb;
    ld = 1'b1;
    @(posedge clk);
    #1 ld = 1'b0;
    #2;
  endtask

  task automatic t_idle();
    put(NOP, NOP, NOP, NOP);
    chk("R2", "idle fwd_a", fwd_a, 0);
    chk("R2", "idle fwd_b", fwd_b, 0);
    chk("R5", "idle stall", {pc_hold, ifid_hold, idex_bubble}, 0);
    chk("R8", "idle flush", ifid_flush, 0);
  endtask

  task automatic t_exmem();
    put(NOP, mk(3, 4, 9, 1, 0, 0, 0), mk(0, 0, 3, 1, 0, 0, 0), NOP);
    chk("R1", "mem match rs fwd_a", fwd_a, 2);
    chk("R1", "mem match rs fwd_b", fwd_b, 0);
    put(NOP, mk(3, 4, 9, 1, 0, 0, 0), mk(0, 0, 4, 1, 0, 0, 0), NOP);
    chk("R1", "mem match rt fwd_b", fwd_b, 2);
    chk("R1", "mem match rt fwd_a", fwd_a, 0);
  endtask

  task automatic t_memwb();
    put(NOP, mk(3, 4, 9, 1, 0, 0, 0), mk(0, 0, 8, 1, 0, 0, 0), mk(0, 0, 4, 1, 0, 0, 0));
    chk("R2", "wb match fwd_b", fwd_b, 1);
    chk("R2", "no match fwd_a", fwd_a, 0);
  endtask

  task automatic t_prio();
    put(NOP, mk(5, 5, 9, 1, 0, 0, 0), mk(0, 0, 5, 1, 0, 0, 0), mk(0, 0, 5, 1, 0, 0, 0));
    chk("R3", "both match fwd_a", fwd_a, 2);
    chk("R3", "both match fwd_b", fwd_b, 2);
  endtask

  task automatic t_zero();
    put(NOP, mk(0, 0, 9, 1, 0, 0, 0), mk(0, 0, 0, 1, 0, 0, 0), mk(0, 0, 0, 1, 0, 0, 0));
    chk("R4", "reg0 fwd_a", fwd_a, 0);
    chk("R4", "reg0 fwd_b", fwd_b, 0);
    put(NOP, mk(3, 3, 9, 1, 0, 0, 0), mk(0, 0, 3, 0, 0, 0, 0), mk(0, 0, 3, 0, 0, 0, 0));
    chk("R4", "wen clear fwd_a", fwd_a, 0);
    put(mk(0, 6, 0, 0, 0, 1, 0), mk(0, 0, 0, 1, 1, 0, 0), NOP, NOP);
    chk("R4", "load reg0 no stall", pc_hold, 0);
    put(mk(6, 0, 0, 0, 0, 1, 0), NOP, mk(0, 0, 6, 0, 0, 0, 0), NOP);
    chk("R4", "wen clear no id bypass", id_fwd_a, 0);
  endtask

  task automatic t_loaduse();
    put(mk(1, 7, 2, 1, 0, 0, 0), mk(0, 0, 7, 1, 1, 0, 0), NOP, NOP);
    chk("R5", "load-use rt pc_hold", pc_hold, 1);
    chk("R5", "load-use rt ifid_hold", ifid_hold, 1);
    chk("R5", "load-use rt bubble", idex_bubble, 1);
    put(mk(7, 1, 2, 1, 0, 0, 0), mk(0, 0, 7, 1, 1, 0, 0), NOP, NOP);
    chk("R5", "load-use rs stall", pc_hold, 1);
    put(mk(6, 8, 2, 1, 0, 0, 0), mk(0, 0, 7, 1, 1, 0, 0), NOP, NOP);
    chk("R5", "load unrelated stall", pc_hold, 0);
    put(mk(7, 1, 2, 1, 0, 0, 0), mk(0, 0, 7, 1, 0, 0, 0), NOP, NOP);
    chk("R5", "alu producer no stall", pc_hold, 0);
  endtask

  task automatic t_brdep();
    put(mk(2, 0, 0, 0, 0, 1, 0), mk(0, 0, 2, 1, 0, 0, 0), NOP, NOP);
    chk("R6", "branch on ex alu stall", pc_hold, 1);
    put(mk(0, 2, 0, 0, 0, 1, 0), NOP, mk(0, 0, 2, 1, 1, 0, 0), NOP);
    chk("R6", "branch on mem load stall", idex_bubble, 1);
    chk("R7", "no id bypass of load", id_fwd_b, 0);
    put(mk(2, 0, 0, 0, 0, 1, 0), NOP, mk(0, 0, 2, 1, 0, 0, 0), NOP);
    chk("R6", "branch on mem alu no stall", pc_hold, 0);
    chk("R7", "id bypass a", id_fwd_a, 1);
    chk("R7", "id bypass b idle", id_fwd_b, 0);
    put(mk(0, 2, 0, 0, 0, 1, 0), NOP, NOP, mk(0, 0, 2, 1, 0, 0, 0));
    chk("R6", "branch on wb no stall", pc_hold, 0);
    chk("R7", "no id bypass from wb", id_fwd_b, 0);
  endtask

  task automatic t_flush();
    put(mk(1, 2, 0, 0, 0, 1, 1), NOP, NOP, NOP);
    chk("R8", "taken flush", ifid_flush, 1);
    chk("R8", "taken no stall", pc_hold, 0);
    put(mk(1, 2, 0, 0, 0, 1, 0), NOP, NOP, NOP);
    chk("R8", "untaken no flush", ifid_flush, 0);
    put(mk(1, 2, 0, 0, 0, 1, 1), mk(0, 0, 1, 1, 0, 0, 0), NOP, NOP);
    chk("R8", "taken while stalled", ifid_flush, 0);
  endtask

  task automatic run_prog(output int stalls, output int flushes, output int sel_a,
                          output int idf);
    stalls = 0; flushes = 0; sel_a = -1; idf = 0;
    put(NOP, NOP, NOP, NOP);
    pc = 0;
    run = 1'b1;
    for (int c = 0; c < 7; c++) begin
      @(posedge clk);
      #3;
      if (pc_hold) stalls++;
      if (ifid_flush) flushes++;
      if (id_fwd_a) idf++;
      if (exr.rd == 5'd3 && exr.wen) sel_a = fwd_a;
    end
    run = 1'b0;
  endtask

  task automatic t_seq_load();
    int s, f, a, i;
    for (int k = 0; k < 8; k++) prog[k] = NOP;
    prog[0] = mk(0, 0, 1, 1, 1, 0, 0);
    prog[1] = mk(1, 2, 3, 1, 0, 0, 0);
    run_prog(s, f, a, i);
    chk("R5", "sequence load-use stall cycles", s, 1);
    chk("R5", "consumer takes load from wb", a, 1);
  endtask

  task automatic t_seq_branch();
    int s, f, a, i;
    for (int k = 0; k < 8; k++) prog[k] = NOP;
    prog[0] = mk(0, 0, 4, 1, 0, 0, 0);
    prog[1] = mk(4, 5, 0, 0, 0, 1, 1);
    run_prog(s, f, a, i);
    chk("R6", "sequence branch stall cycles", s, 1);
    chk("R7", "sequence id bypass cycles", i, 1);
    chk("R8", "sequence flush cycles", f, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_idle();
    t_exmem();
    t_memwb();
    t_prio();
    t_zero();
    t_loaduse();
    t_brdep();
    t_flush();
    t_seq_load();
    t_seq_branch();
    summary();
  end
endmodule